// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Channel

This block is one DMA channel. It moves data from a peripheral that sits at one fixed address into a run of incrementing memory addresses. The peripheral paces the transfer. Each rising edge on its request line brings in one 8-byte word, which is read from the source port and acknowledged. The words collect in a 64-byte staging buffer. The memory side drains that buffer through a burst write port, one 32-byte burst (four 8-byte beats) at a time.

Software arms the channel with a start pulse. The channel then takes descriptors one at a time. Each descriptor gives a destination start address, a byte count and a flag that marks the final descriptor. When a descriptor's count runs out, any remainder shorter than a burst goes out as a short final burst. On the final read of the final descriptor, the channel drives a done output to the peripheral.

The peripheral can also end the transfer early by pulsing its own done line. The channel then stops reading, writes out everything still buffered, raises a sticky end-of-transfer interrupt and returns to idle. While idle it ignores requests until the next start pulse.

Top module: `p2m_dma_channel`

## Requirements
- R1: After reset the channel is idle: `idle`=1, `irq`=0, `desc_ready`=0, and `src_rd` and `wr_valid` are both 0.
- R2: During a transfer with bytes still to read, each rising edge on `dreq` produces exactly one source read strobe. The strobe's address is the `src_addr` value latched at start. `dack` is high for exactly one cycle, in the cycle right after the strobe.
- R3: The buffer holds at most 8 unwritten 8-byte beats. A request that arrives while all 8 are occupied waits, and its read is issued once a beat has been written out.
- R4: Whenever at least 4 beats are unwritten, a burst of 4 beats is launched with `wr_len`=32. Beats carry the read data in read order. Beat addresses start at the descriptor's destination and rise by 8 per beat. `wr_first` marks the first beat of each burst.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_first` hold their values.
- R6: When a descriptor's count is used up, the remaining fewer-than-4 beats go out as one burst with `wr_len` equal to their byte count. The channel then asks for the next descriptor. After the final descriptor it sets `irq` and goes idle.
- R7: `done_out` is high only in the cycle of the read strobe that uses up the final descriptor's count, and never at any other time.
- R8: A `done_in` pulse stops further reads. The channel writes out every buffered beat, then sets `irq` and goes idle, and `done_out` is not driven.
- R9: While idle, `dreq` edges cause no read and no write.
- R10: `irq` stays set until an `irq_clr` pulse clears it. `idle` reads 1 while the channel is stopped.
- R11: `start` has effect only while idle. After `start`, `desc_ready` is high until a descriptor is accepted. Descriptor byte counts are nonzero multiples of 8, and destinations are 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Arm pulse, accepted while idle |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| idle | output | 1 | Channel stopped |
| irq | output | 1 | Sticky end-of-transfer interrupt |
| src_addr | input | AW | Fixed source address, latched at start |
| dreq | input | 1 | Peripheral request, rising edge counts |
| dack | output | 1 | Acknowledge, one cycle per completed read |
| done_in | input | 1 | Peripheral early-termination pulse |
| done_out | output | 1 | High with the final read strobe |
| src_rd | output | 1 | Source read strobe; data is taken at the end of this cycle |
| src_raddr | output | AW | Source read address |
| src_rdata | input | DW | Source read data |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Channel accepts a descriptor |
| desc_dst | input | AW | Destination start address |
| desc_bytes | input | CNT_W | Byte count of the descriptor |
| desc_last | input | 1 | Final descriptor flag |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_first | output | 1 | First beat of a burst |
| wr_addr | output | AW | Beat address |
| wr_len | output | LEN_W | Byte length of the current burst |
| wr_data | output | DW | Beat data |

## Verification
The read strobe appears one cycle after the cycle in which a `dreq` rising edge is sampled. `dack` follows one cycle after the strobe, and `done_out` rises in the same cycle as the strobe. A burst's first beat appears in the cycle after the buffer reaches four unwritten beats, and each beat is consumed at the edge where `wr_ready` is high. The bench drives inputs on falling edges and samples outputs 2 ns later. Each check therefore compares values that are stable for the coming rising edge, with no race against the design's registers. Expected beats and burst lengths go into queues as each descriptor is issued, and a monitor pops them as beats are accepted.

// File: rtl/p2m_dma_pkg.sv
package p2m_dma_pkg;
    typedef enum logic [1:0] {
        CH_IDLE,
        CH_LOAD,
        CH_RUN,
        CH_FLUSH
    } ch_state_e;
endpackage

// File: rtl/p2m_stage_buf.sv
// Staging ring buffer: one write port, one read port, occupancy in beats.
module p2m_stage_buf #(
    parameter  int DW    = 64,
    parameter  int DEPTH = 8,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wp = ptr_q.wp + 1'b1;
        if (pop)  ptr_d.rp = ptr_q.rp + 1'b1;
        ptr_d.cnt = ptr_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[ptr_q.wp] <= push_data;
    end

    assign head  = mem_q[ptr_q.rp];
    assign count = ptr_q.cnt;
endmodule

// File: rtl/p2m_burst_gen.sv
// Tracks the beats left in the current write burst and its byte length.
module p2m_burst_gen #(
    parameter  int BURST_BEATS = 4,
    parameter  int BEAT_BYTES  = 8,
    localparam int BW = $clog2(BURST_BEATS + 1),
    localparam int LW = $clog2(BURST_BEATS * BEAT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [BW-1:0] launch_beats,
    input  logic          beat_acc,
    output logic          active,
    output logic          first,
    output logic [LW-1:0] len_bytes
);
    typedef struct packed {
        logic [BW-1:0] left;
        logic          first;
        logic [LW-1:0] len;
    } burst_t;

    burst_t bs_d, bs_q;

    always_comb begin
        bs_d = bs_q;
        if (launch) begin
            bs_d.left  = launch_beats;
            bs_d.first = 1'b1;
            bs_d.len   = LW'(launch_beats) * LW'(BEAT_BYTES);
        end else if (beat_acc) begin
            bs_d.left  = bs_q.left - 1'b1;
            bs_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign active    = (bs_q.left != '0);
    assign first     = bs_q.first;
    assign len_bytes = bs_q.len;
endmodule

// File: rtl/p2m_dma_channel.sv
module p2m_dma_channel
    import p2m_dma_pkg::*;
#(
    parameter  int AW          = 32,
    parameter  int DW          = 64,
    parameter  int CNT_W       = 16,
    parameter  int BUF_BEATS   = 8,
    parameter  int BURST_BEATS = 4,
    localparam int BEAT_BYTES  = DW / 8,
    localparam int LEN_W       = $clog2(BURST_BEATS * BEAT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             irq_clr,
    output logic             idle,
    output logic             irq,
    input  logic [AW-1:0]    src_addr,
    input  logic             dreq,
    output logic             dack,
    input  logic             done_in,
    output logic             done_out,
    output logic             src_rd,
    output logic [AW-1:0]    src_raddr,
    input  logic [DW-1:0]    src_rdata,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [AW-1:0]    desc_dst,
    input  logic [CNT_W-1:0] desc_bytes,
    input  logic             desc_last,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic             wr_first,
    output logic [AW-1:0]    wr_addr,
    output logic [LEN_W-1:0] wr_len,
    output logic [DW-1:0]    wr_data
);
    localparam int OCC_W = $clog2(BUF_BEATS + 1);
    localparam int BW    = $clog2(BURST_BEATS + 1);

    typedef struct packed {
        ch_state_e        st;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [CNT_W-1:0] remain;
        logic             last;
        logic             req_pend;
        logic             dreq_q;
        logic             rd;
        logic             done_o;
        logic             ack;
        logic             irq;
    } ch_t;

    ch_t ch_d, ch_q;

    logic [OCC_W-1:0] occ;
    logic [DW-1:0]    head;
    logic             active, first, launch, beat_acc, issue, req_edge;
    logic [BW-1:0]    launch_beats;
    logic [LEN_W-1:0] len_bytes;

    p2m_stage_buf #(.DW(DW), .DEPTH(BUF_BEATS)) i_buf (
        .clk(clk), .rst_n(rst_n),
        .push(ch_q.rd), .push_data(src_rdata),
        .pop(beat_acc), .head(head), .count(occ)
    );

    p2m_burst_gen #(.BURST_BEATS(BURST_BEATS), .BEAT_BYTES(BEAT_BYTES)) i_burst (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_beats(launch_beats), .beat_acc(beat_acc),
        .active(active), .first(first), .len_bytes(len_bytes)
    );

    assign beat_acc     = active && wr_ready;
    assign launch       = !active && ((occ >= OCC_W'(BURST_BEATS)) ||
                          (ch_q.st == CH_FLUSH && occ != '0 && !ch_q.rd));
    assign launch_beats = (occ >= OCC_W'(BURST_BEATS)) ? BW'(BURST_BEATS) : BW'(occ);
    assign req_edge     = dreq && !ch_q.dreq_q;
    assign issue        = (ch_q.st == CH_RUN) && (ch_q.req_pend || req_edge) &&
                          (ch_q.remain != '0) && !ch_q.rd &&
                          (occ < OCC_W'(BUF_BEATS)) && !done_in;
    assign desc_ready   = (ch_q.st == CH_LOAD) && !done_in;

    always_comb begin
        ch_d          = ch_q;
        ch_d.dreq_q   = dreq;
        ch_d.req_pend = (ch_q.st == CH_LOAD || ch_q.st == CH_RUN) &&
                        (ch_q.req_pend || req_edge) && !issue;
        ch_d.rd       = issue;
        ch_d.done_o   = issue && ch_q.last && (ch_q.remain == CNT_W'(BEAT_BYTES));
        ch_d.ack      = ch_q.rd;
        if (issue)    ch_d.remain = ch_q.remain - CNT_W'(BEAT_BYTES);
        if (beat_acc) ch_d.dst    = ch_q.dst + AW'(BEAT_BYTES);
        if (irq_clr)  ch_d.irq    = 1'b0;
        unique case (ch_q.st)
            CH_IDLE: if (start) begin
                ch_d.st  = CH_LOAD;
                ch_d.src = src_addr;
            end
            CH_LOAD: if (done_in) begin
                ch_d.st   = CH_FLUSH;
                ch_d.last = 1'b1;
            end else if (desc_valid) begin
                ch_d.st     = CH_RUN;
                ch_d.dst    = desc_dst;
                ch_d.remain = desc_bytes;
                ch_d.last   = desc_last;
            end
            CH_RUN: if (done_in) begin
                ch_d.st     = CH_FLUSH;
                ch_d.last   = 1'b1;
                ch_d.remain = '0;
            end else if (ch_q.remain == '0 && !ch_q.rd) begin
                ch_d.st = CH_FLUSH;
            end
            CH_FLUSH: if (occ == '0 && !active && !ch_q.rd) begin
                if (ch_q.last) begin
                    ch_d.st  = CH_IDLE;
                    ch_d.irq = 1'b1;
                end else begin
                    ch_d.st = CH_LOAD;
                end
            end
            default: ch_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign idle      = (ch_q.st == CH_IDLE);
    assign irq       = ch_q.irq;
    assign dack      = ch_q.ack;
    assign done_out  = ch_q.done_o;
    assign src_rd    = ch_q.rd;
    assign src_raddr = ch_q.src;
    assign wr_valid  = active;
    assign wr_first  = first;
    assign wr_addr   = ch_q.dst;
    assign wr_len    = len_bytes;
    assign wr_data   = head;
endmodule

// File: rtl/p2m_dma_sva.sv
module p2m_dma_sva #(
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int LEN_W = 6,
    parameter int BEAT  = 8,
    parameter int BURST = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle,
    input logic             irq,
    input logic             irq_clr,
    input logic             dack,
    input logic             done_out,
    input logic             src_rd,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             wr_first,
    input logic [AW-1:0]    wr_addr,
    input logic [LEN_W-1:0] wr_len,
    input logic [DW-1:0]    wr_data
);
    p_ack_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd |=> dack);
    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> !dack);
    p_burst_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_valid && wr_ready) && wr_valid && !wr_first) |->
        (wr_addr == $past(wr_addr) + AW'(BEAT)));
    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_len != '0 && wr_len <= LEN_W'(BURST)));
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=>
        (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_first)));
    p_done_with_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_out |-> src_rd);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!src_rd && !wr_valid));
    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

bind p2m_dma_channel p2m_dma_sva #(
    .AW(AW), .DW(DW), .LEN_W(LEN_W), .BEAT(BEAT_BYTES), .BURST(BURST_BEATS * BEAT_BYTES)
) i_p2m_dma_sva (
    .clk(clk), .rst_n(rst_n), .idle(idle), .irq(irq), .irq_clr(irq_clr),
    .dack(dack), .done_out(done_out), .src_rd(src_rd),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_first(wr_first),
    .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data)
);

// File: tb/test_p2m_dma_channel.sv
module test_p2m_dma_channel;
    localparam int AW = 32, DW = 64, CNT_W = 16, LEN_W = 6;
    localparam logic [AW-1:0] SRC = 32'hF000_0040;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, start, irq_clr, idle, irq, dreq, dack, done_in, done_out, src_rd;
    logic [AW-1:0] src_raddr, desc_dst, wr_addr;
    logic [DW-1:0] src_rdata, wr_data;
    logic desc_valid, desc_ready, desc_last, wr_valid, wr_ready, wr_first;
    logic [CNT_W-1:0] desc_bytes;
    logic [LEN_W-1:0] wr_len;

    p2m_dma_channel i_p2m_dma_channel (
        .clk(clk), .rst_n(rst_n), .start(start), .irq_clr(irq_clr), .idle(idle), .irq(irq),
        .src_addr(SRC), .dreq(dreq), .dack(dack), .done_in(done_in), .done_out(done_out),
        .src_rd(src_rd), .src_raddr(src_raddr), .src_rdata(src_rdata),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_dst(desc_dst),
        .desc_bytes(desc_bytes), .desc_last(desc_last),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_first(wr_first),
        .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data)
    );

    int n_chk = 0, n_err = 0, rd_idx = 0, done_idx = -1;
    bit mon_on = 0;
    logic prev_rd = 1'b0;
    logic [AW-1:0] q_addr[$];
    logic [DW-1:0] q_data[$];
    int            q_len[$];

    function automatic logic [DW-1:0] pat(int i);
        return {32'hD00D_0000 + 32'(i), ~32'(i)};
    endfunction

    assign src_rdata = pat(rd_idx);
    always @(posedge clk) if (rst_n && src_rd) rd_idx <= rd_idx + 1;

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n && mon_on) begin
            if (prev_rd) chk(dack === 1'b1, "R2 dack after read", dack, 1);
            if (src_rd) begin
                chk(src_raddr === SRC, "R2 source address", src_raddr, SRC);
                chk(done_out === (rd_idx == done_idx), "R7 done_out on read",
                    done_out, (rd_idx == done_idx));
            end else if (done_out) chk(1'b0, "R7 done_out without read", 1, 0);
            if (wr_valid && wr_ready) begin
                if (q_data.size() == 0) chk(1'b0, "R4 unexpected beat", wr_addr, 0);
                else begin
                    logic [AW-1:0] ea;
                    logic [DW-1:0] ed;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    chk(wr_addr === ea, "R4 beat address", wr_addr, ea);
                    chk(wr_data === ed, "R4 beat data", wr_data, ed);
                end
                if (wr_first) begin
                    if (q_len.size() == 0) chk(1'b0, "R6 unexpected burst", wr_len, 0);
                    else begin
                        int el;
                        el = q_len.pop_front();
                        chk(int'(wr_len) == el, "R4/R6 burst length", wr_len, el);
                    end
                end
            end
            prev_rd = src_rd;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic req_pulse();
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
    endtask
    task automatic start_pulse();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask
    task automatic clr_pulse();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask
    task automatic done_pulse();
        @(negedge clk); done_in = 1'b1;
        @(negedge clk); done_in = 1'b0;
    endtask
    task automatic give_desc(logic [AW-1:0] a, int bytes, bit last);
        @(negedge clk);
        while (!desc_ready) @(negedge clk);
        desc_valid = 1'b1; desc_dst = a; desc_bytes = CNT_W'(bytes); desc_last = last;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask
    task automatic expect_beats(logic [AW-1:0] a, int n, int base);
        for (int k = 0; k < n; k++) begin
            q_addr.push_back(a + AW'(8 * k));
            q_data.push_back(pat(base + k));
        end
    endtask
    task automatic wait_idle(string tag);
        int t = 0;
        while (!idle && t < 3000) begin @(negedge clk); t++; end
        #3;
        chk(idle === 1'b1, tag, idle, 1);
    endtask
    task automatic req_train(int n, int gap);
        for (int k = 0; k < n; k++) begin req_pulse(); wait_cyc(gap); end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int r0;
        rst_n = 1'b0; start = 0; irq_clr = 0; dreq = 0; done_in = 0;
        desc_valid = 0; desc_dst = '0; desc_bytes = '0; desc_last = 0; wr_ready = 1'b1;
        wait_cyc(3); #3;
        // R1: reset state
        chk(idle === 1'b1, "R1 idle", idle, 1);
        chk(irq === 1'b0, "R1 irq", irq, 0);
        chk(desc_ready === 1'b0, "R1 desc_ready", desc_ready, 0);
        chk(src_rd === 1'b0 && wr_valid === 1'b0, "R1 no activity", {src_rd, wr_valid}, 0);
        @(negedge clk); rst_n = 1'b1; mon_on = 1;

        // T1: single descriptor, 6 beats -> bursts 4 and 2
        start_pulse(); #3;
        chk(desc_ready === 1'b1 && idle === 1'b0, "R11 armed", {desc_ready, idle}, 2'b10);
        expect_beats(32'h1000, 6, 0); q_len.push_back(32); q_len.push_back(16); done_idx = 5;
        give_desc(32'h1000, 48, 1);
        req_train(6, 3);
        wait_idle("R6 idle after count");
        chk(irq === 1'b1, "R6 irq after last descriptor", irq, 1);
        chk(q_data.size() == 0 && q_len.size() == 0, "R4 all beats written", q_data.size(), 0);
        wait_cyc(5);
        chk(irq === 1'b1, "R10 irq sticky", irq, 1);
        clr_pulse(); #3;
        chk(irq === 1'b0, "R10 irq cleared", irq, 0);

        // T2: two descriptors -> 4,1 then 2
        start_pulse();
        expect_beats(32'h2000, 5, 6); expect_beats(32'h3000, 2, 11);
        q_len.push_back(32); q_len.push_back(8); q_len.push_back(16); done_idx = 12;
        fork
            begin give_desc(32'h2000, 40, 0); give_desc(32'h3000, 16, 1); end
            req_train(7, 8);
        join
        wait_idle("R6 idle after chain");
        chk(q_data.size() == 0 && q_len.size() == 0, "R6 chained beats written", q_data.size(), 0);
        clr_pulse();

        // T3: memory stalled, buffer fills, request held off
        start_pulse();
        expect_beats(32'h4000, 10, 13);
        q_len.push_back(32); q_len.push_back(32); q_len.push_back(16); done_idx = 22;
        @(negedge clk); wr_ready = 1'b0;
        give_desc(32'h4000, 80, 1);
        r0 = rd_idx;
        req_train(9, 3);
        wait_cyc(10); #3;
        chk(rd_idx - r0 == 8, "R3 reads capped at buffer size", rd_idx - r0, 8);
        chk(wr_valid === 1'b1 && wr_addr === 32'h4000, "R5 stalled beat", wr_addr, 32'h4000);
        begin
            logic [AW-1:0] a0;
            logic [DW-1:0] d0;
            a0 = wr_addr; d0 = wr_data;
            wait_cyc(5); #3;
            chk(wr_addr === a0 && wr_data === d0, "R5 held during stall", wr_data, d0);
        end
        @(negedge clk); wr_ready = 1'b1;
        wait_cyc(10); #3;
        chk(rd_idx - r0 == 9, "R3 held request served", rd_idx - r0, 9);
        req_pulse();
        wait_idle("R6 idle after stall run");
        chk(q_data.size() == 0 && q_len.size() == 0, "R3 all beats written", q_data.size(), 0);
        clr_pulse();

        // T4: early termination by done_in
        start_pulse();
        expect_beats(32'h5000, 6, 23); q_len.push_back(32); q_len.push_back(16); done_idx = -1;
        give_desc(32'h5000, 80, 1);
        req_train(6, 3);
        wait_cyc(6);
        done_pulse();
        wait_idle("R8 idle after done_in");
        chk(irq === 1'b1, "R8 irq after done_in", irq, 1);
        chk(q_data.size() == 0 && q_len.size() == 0, "R8 buffer flushed", q_data.size(), 0);
        r0 = rd_idx;
        req_train(2, 4);
        wait_cyc(10); #3;
        chk(rd_idx == r0, "R9 requests ignored while idle", rd_idx, r0);
        chk(idle === 1'b1, "R9 stays idle", idle, 1);
        clr_pulse();

        // T5: restart after stop
        start_pulse();
        expect_beats(32'h6000, 4, 29); q_len.push_back(32); done_idx = 32;
        give_desc(32'h6000, 32, 1);
        req_train(4, 3);
        wait_idle("R11 idle after restart");
        chk(irq === 1'b1 && q_data.size() == 0, "R11 restart completes", q_data.size(), 0);
        clr_pulse();

        wait_cyc(3);
        summary();
        $finish;
    end
endmodule